// File: doc/BRIEF.md
# Clock Divider and Squasher Chain

This block turns a fast PLL clock into a slower display-core clock without leaving the PLL clock domain. It does not gate or divide the clock itself. It produces an enable pulse, `ce_out`, that marks the rising edges of the derived clock, and a companion level, `clk_out`, that toggles at the derived rate. Three stages in fixed order shape the pulse train:
- an integer-or-half divider picked from four settings;
- a squasher that walks a programmable bit waveform and drops the divider pulses that meet a zero bit;
- a fixed halving stage.

Software posts a new divider setting and a new waveform together on a single-cycle request. The divider part waits in a pending register until the next start-of-vblank strobe. The waveform part waits until the current pattern reaches its last bit. This keeps every switch free of glitches, and the old pattern always finishes a whole period. A request whose waveform has no one bit inside its active length, or whose length is out of range, is refused as a whole and flagged. `busy` and `done` report the progress of the two pending updates.

Top module: `clkdiv_squash`

## Requirements
- R1: The divider code selects the spacing of divider pulses in input cycles: code 0 gives a pulse every cycle, code 2 every 2 cycles, code 3 every 4 cycles. Code 1 alternates spacings of 1 and 2 cycles, which divides by 1.5, and it starts with the spacing of 1 after the code is applied.
- R2: The waveform has 16 bits and a 5-bit length L. Bits 15 down to 16-L are used, most significant bit first, one bit per divider pulse. The pattern repeats after bit 16-L. A divider pulse passes when its bit is 1 and is suppressed when its bit is 0.
- R3: `clk_out` toggles on every pulse that passes the squasher. `ce_out` is high when such a pulse occurs while `clk_out` is low. The `ce_out` rate is therefore fin / divider × (ones / L) / 2.
- R4: After reset the divider code is 2, the waveform is all ones with L = 16, and `clk_out`, `busy`, `done` and `err` are 0.
- R5: An accepted divider code has no effect until a cycle with `vblank` high. At the clock edge that ends that cycle it takes effect, and its first divider pulse occurs in the next cycle.
- R6: An accepted waveform is loaded only at the divider pulse that consumes the last bit of the current pattern. The new pattern's first bit is used on the next divider pulse.
- R7: A single request carries both updates. Each update is applied on its own trigger, in either order, back to back.
- R8: A request is refused as a whole when L is 0, when L is above 16, or when the used bits are all zero. In that case `err` is high for exactly the one cycle after the request, and no setting changes.
- R9: `busy` is high from the cycle after an accepted request until both updates have been applied. `done` is high for exactly the first cycle in which `busy` reads low again.
- R10: A new accepted request made while updates are still pending replaces the pending values of both updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle update request |
| req_div | input | 2 | Requested divider code (0:/1, 1:/1.5, 2:/2, 3:/4) |
| req_wave | input | 16 | Requested squash waveform, used from bit 15 down |
| req_len | input | 5 | Requested waveform length, 1 to 16 |
| vblank | input | 1 | Start-of-vblank strobe |
| busy | output | 1 | Updates pending |
| done | output | 1 | One-cycle pulse when the last pending update has been applied |
| err | output | 1 | One-cycle flag for a refused request |
| ce_out | output | 1 | Enable pulse at each derived-clock rising edge |
| clk_out | output | 1 | Derived clock level |

## Verification
`ce_out` and `clk_out` are same-cycle functions of the registered state. A request or strobe present in cycle n therefore first changes them in cycle n+1. `err` and `busy` also answer in cycle n+1, and `done` appears in the cycle after the last pending flag clears. A behavioural model in the bench is stepped with the inputs of cycle n. The model and the design are compared at the falling edge that follows the next rising edge, so both sides are compared on the same cycle. Two rate windows count `ce_out` pulses against the R3 formula, with a tolerance of one pulse.

// File: rtl/clkdiv_squash.sv
module clkdiv_squash #(
  parameter int WAVE_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_div,
  input  logic [WAVE_W-1:0] req_wave,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              vblank,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              ce_out,
  output logic              clk_out
);
  localparam int IDX_W = $clog2(WAVE_W);

  logic [1:0]        div_q, div_nx, cnt_q, reload;
  logic [WAVE_W-1:0] wave_q, wave_nx;
  logic [LEN_W-1:0]  len_q, len_nx;
  logic [IDX_W-1:0]  idx_q;
  logic              alt_q, div_pend, wave_pend, busy_q, err_q, clk_q;
  logic              div_ce, last, sq_ce, bad;

  assign div_ce  = (cnt_q == 2'd0);
  assign last    = (LEN_W'(idx_q) == len_q - 1'b1);
  assign sq_ce   = div_ce & wave_q[IDX_W'(WAVE_W-1) - idx_q];
  assign bad     = (req_len == '0) || (req_len > LEN_W'(WAVE_W)) ||
                   ((req_wave & ~({WAVE_W{1'b1}} >> req_len)) == '0);
  assign busy    = div_pend | wave_pend;
  assign done    = busy_q & ~busy;
  assign err     = err_q;
  assign clk_out = clk_q;
  assign ce_out  = sq_ce & ~clk_q;

  always_comb begin
    case (div_q)
      2'd0:    reload = 2'd0;
      2'd1:    reload = alt_q ? 2'd1 : 2'd0;
      2'd2:    reload = 2'd1;
      default: reload = 2'd3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= 2'd2;  div_nx <= 2'd2;
      wave_q <= '1;   wave_nx <= '1;
      len_q <= LEN_W'(WAVE_W); len_nx <= LEN_W'(WAVE_W);
      idx_q <= '0;    cnt_q <= '0;  alt_q <= 1'b0;
      div_pend <= 1'b0; wave_pend <= 1'b0;
      busy_q <= 1'b0; err_q <= 1'b0; clk_q <= 1'b0;
    end else begin
      busy_q <= busy;
      err_q  <= req_valid & bad;
      if (sq_ce) clk_q <= ~clk_q;
      if (div_ce) begin
        cnt_q <= reload;
        alt_q <= ~alt_q;
        if (last) begin
          idx_q <= '0;
          if (wave_pend) begin
            wave_q    <= wave_nx;
            len_q     <= len_nx;
            wave_pend <= 1'b0;
          end
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (vblank && div_pend) begin
        div_q    <= div_nx;
        cnt_q    <= '0;
        alt_q    <= 1'b0;
        div_pend <= 1'b0;
      end
      if (req_valid && !bad) begin
        div_nx    <= req_div;
        wave_nx   <= req_wave;
        len_nx    <= req_len;
        div_pend  <= 1'b1;
        wave_pend <= 1'b1;
      end
    end
  end

  AST_DIV_ONLY_AT_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> $stable(div_q)); // R5
  AST_WAVE_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_ce && last) |=> $stable(wave_q)); // R6
  AST_WAVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wave_q != '0); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bad) |=> busy); // R9
  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ce_out |=> clk_out); // R3
endmodule

// File: tb/clkdiv_squash_bench.sv
module clkdiv_squash_bench;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, vblank = 1'b0;
  logic [1:0] req_div = '0;
  logic [15:0] req_wave = '0;
  logic [4:0] req_len = '0;
  logic busy, done, err, ce_out, clk_out;

  always #2 clk = ~clk;

  clkdiv_squash u_clkdiv_squash (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_div(req_div),
    .req_wave(req_wave), .req_len(req_len), .vblank(vblank), .busy(busy),
    .done(done), .err(err), .ce_out(ce_out), .clk_out(clk_out));

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;
  string phase = "R4";

  int m_div = 2, m_gap = 0, m_pos = 0, m_len = 16, n_div = 2, n_len = 16;
  bit m_ph = 0, m_clk = 0, m_dp = 0, m_wp = 0, m_done = 0, m_err = 0;
  logic [15:0] m_wave = 16'hFFFF, n_wave = 16'hFFFF;
  int win1 = 0, win2 = 0;

  task automatic chk(string tag, logic got, logic exp, string what);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %0b exp %0b at cycle %0d", tag, what, got, exp, cyc);
    end
  endtask

  task automatic chk_rate(string tag, int got, int exp);
    n_vec++;
    if (got < exp - 1 || got > exp + 1) begin
      n_bad++;
      $display("FAIL %s ce_out count got %0d exp %0d", tag, got, exp);
    end
  endtask

  function automatic bit e_pulse();
    return m_gap == 0;
  endfunction
  function automatic bit e_sq();
    return e_pulse() && m_wave[15 - m_pos];
  endfunction

  task automatic compare();
    string t;
    t = phase;
    chk({t, "/R3"}, ce_out, e_sq() && !m_clk, "ce_out");
    chk({t, "/R3"}, clk_out, m_clk, "clk_out");
    chk({t, "/R9"}, busy, m_dp || m_wp, "busy");
    chk({t, "/R9"}, done, m_done, "done");
    chk({t, "/R8"}, err, m_err, "err");
  endtask

  task automatic request(int d, logic [15:0] w, int l);
    req_valid = 1'b1; req_div = 2'(d); req_wave = w; req_len = 5'(l);
  endtask

  task automatic stim(int c);
    req_valid = 1'b0; vblank = 1'b0;
    case (c)
      10:   begin phase = "R1"; request(0, 16'hAAAA, 16); end
      200:  begin phase = "R2"; request(1, 16'hF0F0, 8); end
      300:  begin phase = "R8"; request(3, 16'h0000, 4); end
      310:  request(3, 16'hFFFF, 0);
      320:  request(3, 16'h0FFF, 4);
      330:  request(3, 16'hFFFF, 17);
      400:  begin phase = "R10"; request(3, 16'h8000, 1); end
      420:  request(2, 16'hC000, 3);
      600:  phase = "R5";
      800:  begin phase = "R7"; request(1, 16'hFFFF, 5); end
      1000: begin phase = "R6"; request(0, 16'hB000, 4); end
      default: ;
    endcase
    if (c == 60 || c == 100 || c == 250 || c == 600 || c == 801 ||
        c == 1000 || c == 1200) vblank = 1'b1;
  endtask

  task automatic step();
    bit pulse, sq, bsy_old, bad;
    pulse = e_pulse(); sq = e_sq(); bsy_old = m_dp || m_wp;
    if (sq) m_clk = !m_clk;
    if (pulse) begin
      if (m_div == 0) m_gap = 0;
      else if (m_div == 1) m_gap = m_ph ? 1 : 0;
      else if (m_div == 2) m_gap = 1;
      else m_gap = 3;
      m_ph = !m_ph;
      if (m_pos == m_len - 1) begin
        m_pos = 0;
        if (m_wp) begin m_wave = n_wave; m_len = n_len; m_wp = 0; end
      end else m_pos++;
    end else m_gap--;
    if (vblank && m_dp) begin m_div = n_div; m_gap = 0; m_ph = 0; m_dp = 0; end
    m_err = 0;
    if (req_valid) begin
      bad = (req_len == 0) || (req_len > 16);
      if (!bad) bad = ((req_wave >> (16 - req_len)) == 0);
      if (bad) m_err = 1;
      else begin
        n_div = req_div; n_wave = req_wave; n_len = req_len; m_dp = 1; m_wp = 1;
      end
    end
    m_done = bsy_old && !(m_dp || m_wp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R4", clk_out, 1'b0, "clk_out after reset");
    chk("R4", busy, 1'b0, "busy after reset");
    chk("R4", err, 1'b0, "err after reset");
    for (int c = 0; c < 1500; c++) begin
      cyc = c;
      compare();
      if (c >= 100 && c < 196 && ce_out) win1++;
      if (c >= 620 && c < 780 && ce_out) win2++;
      stim(c);
      step();
      @(negedge clk);
    end
    chk_rate("R1", win1, 24);
    chk_rate("R3", win2, 27);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule